// File: doc/BRIEF.md
# Dual-Bank Conversion Start Timer

This block decides when a sixteen-channel simultaneous-sampling front end starts converting. Channels 0 to 7 form the low bank and channels 8 to 15 the high bank. A period counter restarts at each low-bank start. When the counter equals the programmed period, the next low-bank start is issued, so conversions repeat while continuous mode is on. The same counter is also compared with a second, shorter value to start the high bank at a fixed offset inside each period.

A low-bank start can also come from a one-cycle software command or from a falling edge on the external trigger pin. The pin is synchronised, and its low time must reach a minimum number of clocks before the edge is accepted. The pin can instead be used as an output. In that case it carries an active-low pulse of fixed width at every low-bank start.

The block also drives the analog multiplexer select. The select returns to the low bank with each low-bank start and moves to the high bank a fixed number of clocks later.

Top module: `conv_timing_ctrl`

## Requirements
- R1: While `rst_n` is low, `bank0_start`, `bank1_start` and `mux_high` are 0, `trig_out` is 1 and the period counter is cleared.
- R2: Raising `cont_en` gives a `bank0_start` pulse in the next cycle. While `cont_en` stays high, further pulses follow every `low_period`+1 cycles.
- R3: If `high_delay` is from 1 to `low_period`, each `bank0_start` is followed by exactly one `bank1_start`, `high_delay`+1 cycles later. If `high_delay` is 0, or larger than `low_period` in continuous mode, `bank1_start` never pulses.
- R4: A `sw_start` high at a clock edge makes `bank0_start` high in the following cycle and restarts the period count from zero.
- R5: With `cont_en` low, a start gives one `bank0_start` and at most one `bank1_start`, and then the block stays idle.
- R6: In trigger mode 2'b01 (input), an accepted falling edge gives `bank0_start` in the cycle after the (SYNC_STAGES+MIN_LOW_CYC−1)-th rising edge that follows the first edge sampling `trig_in` low.
- R7: A low level on `trig_in` shorter than MIN_LOW_CYC synchronised cycles starts nothing. A pin that is already low when input mode is entered starts nothing until it has gone high and then fallen.
- R8: In trigger modes 2'b00, 2'b10 and 2'b11, `trig_in` has no effect on `bank0_start`.
- R9: `trig_oe` is 1 only in trigger mode 2'b10 (output). In that mode, `trig_out` goes low in the same cycle as each `bank0_start` and stays low for PULSE_CYC cycles. In any other mode it rests at 1.
- R10: `mux_high` is 0 in every cycle where `bank0_start` is high. It rises MUX_DLY_CYC cycles after that `bank0_start`.
- R11: When the high-bank compare and the period end fall in the same cycle (`high_delay` equal to `low_period`), `bank0_start` and `bank1_start` pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cont_en | input | 1 | Continuous conversion enable |
| low_period | input | CNT_W | Period compare value; the period is this value plus one cycle |
| high_delay | input | CNT_W | High-bank compare value; 0 disables the high bank |
| sw_start | input | 1 | Software start command, one cycle |
| trig_mode | input | 2 | 00 off, 01 input, 10 output, 11 off |
| trig_in | input | 1 | Trigger pin level as received |
| trig_out | output | 1 | Trigger pin drive value, active low |
| trig_oe | output | 1 | Trigger pin output enable |
| bank0_start | output | 1 | One-cycle start for channels 0 to 7 |
| bank1_start | output | 1 | One-cycle start for channels 8 to 15 |
| mux_high | output | 1 | Multiplexer select: 1 routes channels 8 to 15 |

## Verification
A high-bank start and the next low-bank start can land in the same cycle when the high compare value equals the period value. The vector table holds such an entry. It checks that both pulses are seen together, that the period stays at `low_period`+1, and that the high-bank offset measured from the previous low-bank start equals `high_delay`+1. A second overlap, a software start landing on a running period, is provoked during continuous operation. It is judged by the gap to the next period-driven start, which must be one full period.

// File: rtl/conv_timing_pkg.sv
package conv_timing_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'b00,
      TRIG_IN   = 2'b01,
      TRIG_OUT  = 2'b10,
      TRIG_RSVD = 2'b11
   } trig_mode_e;

   function automatic logic mode_is_input(input logic [1:0] m);
      return m == TRIG_IN;
   endfunction

   function automatic logic mode_is_output(input logic [1:0] m);
      return m == TRIG_OUT;
   endfunction

endpackage

// File: rtl/ctc_sync.sv
module ctc_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("ctc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RST_VAL;
         else        chain <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ctc_ext_qual.sv
module ctc_ext_qual #(
   parameter int MIN_LOW = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pin_s,
   output logic hit
);
   localparam int LW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);

   logic          armed;
   logic [LW-1:0] low_cnt;

   if (MIN_LOW < 1) begin : g_bad_min
      $error("ctc_ext_qual: MIN_LOW must be at least 1");
   end

   assign hit = enable && armed && !pin_s && (low_cnt == LW'(MIN_LOW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         low_cnt <= '0;
      end else if (!enable) begin
         armed   <= 1'b0;
         low_cnt <= '0;
      end else if (pin_s) begin
         armed   <= 1'b1;
         low_cnt <= '0;
      end else if (armed) begin
         if (hit) armed <= 1'b0;
         else     low_cnt <= low_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ctc_period_cnt.sv
module ctc_period_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont_en,
   input  logic             restart,
   input  logic [CNT_W-1:0] low_period,
   input  logic [CNT_W-1:0] high_delay,
   output logic             low_hit,
   output logic             high_hit
);
   logic [CNT_W-1:0] cnt;
   logic             active;
   logic             cont_q;
   logic             run;

   if (CNT_W < 2) begin : g_bad_width
      $error("ctc_period_cnt: CNT_W must be at least 2");
   end

   assign run      = cont_en | active;
   assign low_hit  = cont_en && (!cont_q || cnt == low_period);
   assign high_hit = run && (high_delay != '0) && (cnt == high_delay);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cont_q <= 1'b0;
      end else begin
         cont_q <= cont_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (restart) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (cont_en) begin
         active <= 1'b0;
         cnt    <= cnt + 1'b1;
      end else if (active) begin
         if (cnt == high_delay) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end
endmodule

// File: rtl/ctc_countdown.sv
module ctc_countdown #(
   parameter int LEN = 50,
   parameter int W   = $clog2(LEN + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   output logic [W-1:0] remain
);
   if (LEN < 1) begin : g_bad_len
      $error("ctc_countdown: LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (clr)            remain <= '0;
      else if (load)           remain <= W'(LEN);
      else if (remain != '0)   remain <= remain - 1'b1;
   end
endmodule

// File: rtl/conv_timing_ctrl.sv
module conv_timing_ctrl
   import conv_timing_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW_CYC = 25,
   parameter int MUX_DLY_CYC = 125,
   parameter int PULSE_CYC   = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont_en,
   input  logic [CNT_W-1:0] low_period,
   input  logic [CNT_W-1:0] high_delay,
   input  logic             sw_start,
   input  logic [1:0]       trig_mode,
   input  logic             trig_in,
   output logic             trig_out,
   output logic             trig_oe,
   output logic             bank0_start,
   output logic             bank1_start,
   output logic             mux_high
);
   localparam int MUX_W   = $clog2(MUX_DLY_CYC + 1);
   localparam int PULSE_W = $clog2(PULSE_CYC + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("conv_timing_ctrl: SYNC_STAGES must be at least 2");
   end
   if (MUX_DLY_CYC < 1) begin : g_bad_mux
      $error("conv_timing_ctrl: MUX_DLY_CYC must be at least 1");
   end

   logic               trig_s;
   logic               ext_hit;
   logic               low_hit;
   logic               high_hit;
   logic               start_req;
   logic               in_mode;
   logic               out_mode;
   logic [MUX_W-1:0]   mux_rem;
   logic [PULSE_W-1:0] pulse_rem;
   logic               b0_q, b1_q, mux_q;

   assign in_mode  = mode_is_input(trig_mode);
   assign out_mode = mode_is_output(trig_mode);

   ctc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
   );

   ctc_ext_qual #(.MIN_LOW(MIN_LOW_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .enable(in_mode), .pin_s(trig_s), .hit(ext_hit)
   );

   ctc_period_cnt #(.CNT_W(CNT_W)) u_period (
      .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .restart(start_req),
      .low_period(low_period), .high_delay(high_delay),
      .low_hit(low_hit), .high_hit(high_hit)
   );

   assign start_req = low_hit | sw_start | ext_hit;

   ctc_countdown #(.LEN(MUX_DLY_CYC), .W(MUX_W)) u_mux_dly (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .load(start_req), .remain(mux_rem)
   );

   ctc_countdown #(.LEN(PULSE_CYC), .W(PULSE_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .clr(!out_mode), .load(start_req && out_mode),
      .remain(pulse_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b0_q  <= 1'b0;
         b1_q  <= 1'b0;
         mux_q <= 1'b0;
      end else begin
         b0_q <= start_req;
         b1_q <= high_hit;
         if (start_req)                   mux_q <= 1'b0;
         else if (mux_rem == MUX_W'(1))   mux_q <= 1'b1;
      end
   end

   assign bank0_start = b0_q;
   assign bank1_start = b1_q;
   assign mux_high    = mux_q;
   assign trig_out    = (pulse_rem == '0);
   assign trig_oe     = out_mode;
endmodule

// File: rtl/conv_timing_ctrl_chk.sv
module conv_timing_ctrl_chk #(
   parameter int CNT_W       = 24,
   parameter int MUX_DLY_CYC = 125
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_start,
   input logic [CNT_W-1:0] high_delay,
   input logic             trig_out,
   input logic             trig_oe,
   input logic             bank0_start,
   input logic             bank1_start,
   input logic             mux_high
);
   logic [31:0] since_b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_b0 <= '1;
      else if (bank0_start)       since_b0 <= '0;
      else if (since_b0 != '1)    since_b0 <= since_b0 + 1'b1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!bank0_start && !bank1_start && !mux_high && trig_out));

   a_r4_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start |=> bank0_start);

   a_r3_high_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (bank1_start && $stable(high_delay)) |-> since_b0 == 32'(high_delay));

   a_r3_high_off: assert property (@(posedge clk) disable iff (!rst_n)
      (high_delay == '0 && $stable(high_delay)) |-> !bank1_start);

   a_r9_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bank0_start && trig_oe && $past(trig_oe)) |-> !trig_out);

   a_r10_mux_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      bank0_start |-> !mux_high);

   a_r10_mux_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mux_high) |-> since_b0 == 32'(MUX_DLY_CYC - 1));
endmodule

bind conv_timing_ctrl conv_timing_ctrl_chk #(
   .CNT_W(CNT_W), .MUX_DLY_CYC(MUX_DLY_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .high_delay(high_delay),
   .trig_out(trig_out), .trig_oe(trig_oe), .bank0_start(bank0_start),
   .bank1_start(bank1_start), .mux_high(mux_high)
);

// File: tb/conv_timing_ctrl_tb.sv
module conv_timing_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 8;
   localparam int SYNC  = 2;
   localparam int MINLO = 3;
   localparam int MUXD  = 5;
   localparam int PULSE = 4;
   localparam int NVEC  = 5;
   // columns: low_period, high_delay, expected gap, expected high offset (0 = none)
   localparam int VEC [0:NVEC-1][0:3] = '{
      '{3, 1, 4, 2},
      '{6, 6, 7, 7},
      '{5, 0, 6, 0},
      '{2, 7, 3, 0},
      '{9, 4, 10, 5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic cont_en = 1'b0;
   logic [CNT_W-1:0] low_period = '0;
   logic [CNT_W-1:0] high_delay = '0;
   logic sw_start = 1'b0;
   logic [1:0] trig_mode = 2'b00;
   logic trig_in = 1'b1;
   logic trig_out, trig_oe, bank0_start, bank1_start, mux_high;

   int checks = 0, errors = 0;
   bit done = 0;

   // monitor state
   bit stat_clr = 0;
   int cyc = 0;
   int b0_cnt, b1_cnt, both_cnt, last_b0, gap_min, gap_max, last_gap;
   int b1_off, mux_off, lo_run, lo_last, b0_nolow;
   bit have_b0, mux_prev;

   conv_timing_ctrl #(
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC), .MIN_LOW_CYC(MINLO),
      .MUX_DLY_CYC(MUXD), .PULSE_CYC(PULSE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .low_period(low_period),
      .high_delay(high_delay), .sw_start(sw_start), .trig_mode(trig_mode),
      .trig_in(trig_in), .trig_out(trig_out), .trig_oe(trig_oe),
      .bank0_start(bank0_start), .bank1_start(bank1_start), .mux_high(mux_high)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (stat_clr) begin
         b0_cnt = 0; b1_cnt = 0; both_cnt = 0; last_b0 = 0; have_b0 = 0;
         gap_min = 1 << 30; gap_max = 0; last_gap = 0; b1_off = 0;
         mux_off = 0; lo_run = 0; lo_last = 0; b0_nolow = 0;
      end else begin
         if (bank1_start) begin
            b1_cnt = b1_cnt + 1;
            if (have_b0) b1_off = cyc - last_b0;
         end
         if (bank0_start && bank1_start) both_cnt = both_cnt + 1;
         if (mux_high && !mux_prev && have_b0) mux_off = cyc - last_b0;
         if (bank0_start) begin
            if (have_b0) begin
               last_gap = cyc - last_b0;
               if (last_gap < gap_min) gap_min = last_gap;
               if (last_gap > gap_max) gap_max = last_gap;
            end
            last_b0 = cyc; have_b0 = 1; b0_cnt = b0_cnt + 1;
            if (trig_oe && trig_out) b0_nolow = b0_nolow + 1;
         end
         if (!trig_out) lo_run = lo_run + 1;
         else if (lo_run != 0) begin lo_last = lo_run; lo_run = 0; end
      end
      mux_prev = mux_high;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_stats();
      stat_clr = 1; step(1); stat_clr = 0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int c0;
      #1 rst_n = 1'b0;
      cont_en = 1'b1; low_period = 8'd2;
      step(4);
      // R1: quiet while reset held
      chk("R1 bank0", bank0_start, 0);
      chk("R1 bank1", bank1_start, 0);
      chk("R1 mux", mux_high, 0);
      chk("R1 trig_out", trig_out, 1);
      chk("R1 trig_oe", trig_oe, 0);
      cont_en = 1'b0;
      step(1);
      rst_n = 1'b1;
      step(3);

      // vector table: continuous operation (R2, R3, R11)
      for (int i = 0; i < NVEC; i++) begin
         cont_en = 1'b0;
         low_period = CNT_W'(VEC[i][0]);
         high_delay = CNT_W'(VEC[i][1]);
         step(3);
         clear_stats();
         cont_en = 1'b1;
         step(5 * VEC[i][2] + 2);
         cont_en = 1'b0;
         chk("R2 pulse count", (b0_cnt >= 4) ? 1 : 0, 1);
         chk("R2 gap min", gap_min, VEC[i][2]);
         chk("R2 gap max", gap_max, VEC[i][2]);
         if (VEC[i][3] == 0) chk("R3 no high start", b1_cnt, 0);
         else begin
            chk("R3 high offset", b1_off, VEC[i][3]);
            chk("R3 high count", (b1_cnt >= 3) ? 1 : 0, 1);
         end
         if (VEC[i][1] == VEC[i][0]) chk("R11 coincident starts", (both_cnt > 0) ? 1 : 0, 1);
      end

      // one-shot software start (R4, R5, R10)
      step(3);
      high_delay = 8'd3; low_period = 8'd20;
      step(2);
      clear_stats();
      sw_start = 1'b1;
      step(1);
      sw_start = 1'b0;
      chk("R4 bank0 after sw", bank0_start, 1);
      chk("R10 mux low at start", mux_high, 0);
      step(30);
      chk("R5 single bank0", b0_cnt, 1);
      chk("R5 single bank1", b1_cnt, 1);
      chk("R3 one-shot offset", b1_off, 4);
      chk("R10 mux delay", mux_off, MUXD);
      chk("R10 mux held high", mux_high, 1);

      // software start restarts a running period (R4)
      low_period = 8'd9; high_delay = 8'd0;
      cont_en = 1'b1;
      step(14);
      sw_start = 1'b1; step(1); sw_start = 1'b0;
      step(12);
      chk("R4 period restarted", last_gap, 10);
      cont_en = 1'b0;
      step(3);

      // external trigger accepted (R6)
      trig_mode = 2'b01; trig_in = 1'b1; high_delay = 8'd0;
      step(6);
      clear_stats();
      c0 = cyc;
      trig_in = 1'b0;
      step(12);
      chk("R6 ext start count", b0_cnt, 1);
      chk("R6 ext start cycle", last_b0, c0 + SYNC + MINLO);
      trig_in = 1'b1;
      step(6);

      // short low rejected, and pin already low at mode entry (R7)
      clear_stats();
      trig_in = 1'b0; step(MINLO - 1); trig_in = 1'b1;
      step(10);
      chk("R7 short low ignored", b0_cnt, 0);
      trig_mode = 2'b00; trig_in = 1'b0;
      step(6);
      trig_mode = 2'b01;
      step(12);
      chk("R7 low at entry ignored", b0_cnt, 0);
      trig_in = 1'b1;
      step(4);

      // trigger ignored outside input mode (R8)
      for (int m = 0; m < 4; m++) begin
         if (m == 1) continue;
         trig_mode = 2'(m); trig_in = 1'b1;
         step(4);
         clear_stats();
         trig_in = 1'b0; step(10); trig_in = 1'b1;
         step(4);
         chk("R8 pin ignored", b0_cnt, 0);
      end

      // output pulse (R9)
      trig_mode = 2'b10; low_period = 8'd20;
      step(2);
      clear_stats();
      cont_en = 1'b1;
      step(50);
      cont_en = 1'b0;
      chk("R9 oe in output mode", trig_oe, 1);
      chk("R9 pulse width", lo_last, PULSE);
      chk("R9 low with each start", b0_nolow, 0);
      chk("R9 pulses seen", (b0_cnt >= 2) ? 1 : 0, 1);
      trig_mode = 2'b00;
      step(2);
      chk("R9 oe off", trig_oe, 0);
      chk("R9 idle high", trig_out, 1);

      done = 1;
      finish_run();
   end
endmodule